// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, clock-enable and data-mask pins of a single-data-rate SDRAM from reset until the memory can take normal traffic. While reset is held, and for a stabilization period after it is released, it drives a continuous no-operation command with clock enable high. The data mask is also high during this time, so the memory's data pins stay high-impedance. The stabilization period is a cycle count worked out from the clock frequency in MHz and the required pause in microseconds. The default is 200 us at 50 MHz.

Once the pause has elapsed, the sequencer walks a fixed order of commands. First it precharges all banks. Next it loads the mode register with a mode word set by a parameter. Then it issues a parameterized number (two or more) of auto-refresh commands. A programmable spacing, counted in clock cycles, separates each command from the one after it. After the last refresh spacing has run out, the block asserts a ready flag, releases the data mask and hands the bus over. Ready stays asserted until the next reset.

The state machine has eight states. Its path is ST_STABLE -> ST_PRECHG -> ST_PRE_GAP -> ST_LOADMODE -> ST_MODE_GAP -> ST_REFRESH -> ST_REF_GAP, then back to ST_REFRESH while refreshes remain, otherwise on to ST_READY. ST_READY holds until reset. The transitions are:
- stabilization expired: ST_STABLE to ST_PRECHG.
- gap expired: each *_GAP state to its next command.
- more refreshes: ST_REF_GAP to ST_REFRESH.
- done: ST_REF_GAP to ST_READY.

Every command state lasts exactly one cycle. Parameter limits: the stabilization count is at least 1, each spacing is at least 2, and the refresh count is at least 2.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted, the outputs are as follows. The command is NOP, encoded {cs_n,ras_n,cas_n,we_n} = 0111. sd_cke is 1, sd_dqm is 1 and init_ready is 0.
- R2: Cycle 0 is the first cycle with reset released, and cycles are counted by rising edges after release. Cycles 0 through STAB-1 carry NOP, where STAB = CLK_MHZ*STAB_US. In cycle STAB, precharge-all (0010) is driven with sd_addr[10] = 1.
- R3: Mode register set (0000) is driven exactly T_RP cycles after the precharge. In that cycle sd_addr equals MODE_WORD and sd_ba is 0.
- R4: Exactly REF_COUNT auto-refresh commands (0001) follow. The first comes T_MRD cycles after the mode register set, and each later one comes T_RC cycles after the previous one.
- R5: Each non-NOP command lasts exactly one cycle, and every other cycle carries NOP.
- R6: init_ready rises exactly T_RC cycles after the last refresh and then stays 1 with NOP driven until reset.
- R7: sd_dqm is 1 in every cycle in which init_ready is 0, and 0 in every cycle in which init_ready is 1.
- R8: sd_cke is 1 in every cycle.
- R9: Asserting reset at any point, even mid-sequence or after ready, restarts the whole sequence from the stabilization wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus; A10 on precharge, mode word on mode set |
| sd_ba | output | 2 | Bank address, held 0 |
| sd_dqm | output | 1 | Data mask, high until ready |
| init_ready | output | 1 | Initialization complete |

## Verification
The bench predicts, for every cycle after release, the exact command, address, mask and ready values, so any design that is off by one cycle will fail. That includes a stabilization count one cycle short or long, and a spacing counted as NOP cycles instead of command-to-command cycles. Either mistake shifts every later command and is flagged at the first one.

The bench also counts refreshes over a full run. A refresh loop that compares its counter one step early or late therefore shows as a missing or extra refresh, or as a ready flag that arrives early. Reset is asserted at random points, including during a one-cycle command and after ready. A sequencer that fails to clear its refresh count or timer would then skip the stabilization wait or issue too few refreshes on the next pass. Further checks catch a precharge without A10 set, a mode set carrying the wrong word, and a mask that drops before ready or stays up after it.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_STABLE,
        ST_PRECHG,
        ST_PRE_GAP,
        ST_LOADMODE,
        ST_MODE_GAP,
        ST_REFRESH,
        ST_REF_GAP,
        ST_READY
    } init_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_NOP     = '{1'b0, 1'b1, 1'b1, 1'b1};
    localparam sd_cmd_t CMD_PRECHG  = '{1'b0, 1'b0, 1'b1, 1'b0};
    localparam sd_cmd_t CMD_REFRESH = '{1'b0, 1'b0, 1'b0, 1'b1};
    localparam sd_cmd_t CMD_LOADMR  = '{1'b0, 1'b0, 1'b0, 1'b0};

    localparam int ALLBANK_BIT = 10;

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    localparam logic [W-1:0] START = W'(RST_VAL);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= START;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/init_cmd_drive.sv
module init_cmd_drive
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input  init_state_t       state,
    output sd_cmd_t           cmd,
    output logic [ADDR_W-1:0] addr,
    output logic              dqm,
    output logic              ready
);

    always_comb begin
        cmd   = CMD_NOP;
        addr  = '0;
        dqm   = 1'b1;
        ready = 1'b0;
        unique case (state)
            ST_PRECHG: begin
                cmd               = CMD_PRECHG;
                addr[ALLBANK_BIT] = 1'b1;
            end
            ST_LOADMODE: begin
                cmd  = CMD_LOADMR;
                addr = MODE_WORD;
            end
            ST_REFRESH: begin
                cmd = CMD_REFRESH;
            end
            ST_READY: begin
                dqm   = 1'b0;
                ready = 1'b1;
            end
            ST_STABLE, ST_PRE_GAP, ST_MODE_GAP, ST_REF_GAP: begin
                cmd = CMD_NOP;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                CLK_MHZ   = 50,
    parameter int                STAB_US   = 200,
    parameter int                T_RP      = 3,
    parameter int                T_MRD     = 2,
    parameter int                T_RC      = 8,
    parameter int                REF_COUNT = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [1:0]        sd_ba,
    output logic              sd_dqm,
    output logic              init_ready
);

    localparam int STAB_CYCLES = CLK_MHZ * STAB_US;
    localparam int MAX_A       = (STAB_CYCLES > T_RP) ? STAB_CYCLES : T_RP;
    localparam int MAX_B       = (T_MRD > T_RC) ? T_MRD : T_RC;
    localparam int MAX_WAIT    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W       = $clog2(MAX_WAIT + 1);
    localparam int RC_W        = $clog2(REF_COUNT + 1);

    localparam logic [CNT_W-1:0] GAP_RP  = CNT_W'(T_RP - 2);
    localparam logic [CNT_W-1:0] GAP_MRD = CNT_W'(T_MRD - 2);
    localparam logic [CNT_W-1:0] GAP_RC  = CNT_W'(T_RC - 2);
    localparam logic [RC_W-1:0]  REF_LAST = RC_W'(REF_COUNT);

    init_state_t      state_q, state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic [RC_W-1:0]  refs_q;
    sd_cmd_t          cmd;

    init_wait_timer #(
        .W       (CNT_W),
        .RST_VAL (STAB_CYCLES - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            refs_q <= '0;
        end else if (state_q == ST_REFRESH) begin
            refs_q <= refs_q + 1'b1;
        end
    end

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_STABLE: begin
                if (tmr_expired) state_d = ST_PRECHG;
            end
            ST_PRECHG: begin
                tmr_load = 1'b1;
                tmr_val  = GAP_RP;
                state_d  = ST_PRE_GAP;
            end
            ST_PRE_GAP: begin
                if (tmr_expired) state_d = ST_LOADMODE;
            end
            ST_LOADMODE: begin
                tmr_load = 1'b1;
                tmr_val  = GAP_MRD;
                state_d  = ST_MODE_GAP;
            end
            ST_MODE_GAP: begin
                if (tmr_expired) state_d = ST_REFRESH;
            end
            ST_REFRESH: begin
                tmr_load = 1'b1;
                tmr_val  = GAP_RC;
                state_d  = ST_REF_GAP;
            end
            ST_REF_GAP: begin
                if (tmr_expired) begin
                    state_d = (refs_q == REF_LAST) ? ST_READY : ST_REFRESH;
                end
            end
            ST_READY: begin
                state_d = ST_READY;
            end
            default: begin
                state_d = ST_STABLE;
            end
        endcase
    end

    init_cmd_drive #(
        .ADDR_W    (ADDR_W),
        .MODE_WORD (MODE_WORD)
    ) u_drive (
        .state (state_q),
        .cmd   (cmd),
        .addr  (sd_addr),
        .dqm   (sd_dqm),
        .ready (init_ready)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;
    assign sd_cke   = 1'b1;
    assign sd_ba    = 2'b00;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
    parameter int                ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [ADDR_W-1:0] sd_addr,
    input logic [1:0]        sd_ba,
    input logic              sd_dqm,
    input logic              init_ready
);

    logic [3:0] c;
    assign c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    assert_cke_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke == 1'b1);

    assert_single_cycle_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c != 4'b0111) |=> (c == 4'b0111));

    assert_prechg_a10_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |-> sd_addr[10]);

    assert_mode_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000) |-> (sd_addr == MODE_WORD && sd_ba == 2'b00));

    assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |=> init_ready);

    assert_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |-> (c == 4'b0111));

    assert_dqm_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dqm == !init_ready);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .ADDR_W    (ADDR_W),
    .MODE_WORD (MODE_WORD)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sd_cke     (sd_cke),
    .sd_cs_n    (sd_cs_n),
    .sd_ras_n   (sd_ras_n),
    .sd_cas_n   (sd_cas_n),
    .sd_we_n    (sd_we_n),
    .sd_addr    (sd_addr),
    .sd_ba      (sd_ba),
    .sd_dqm     (sd_dqm),
    .init_ready (init_ready)
);

// File: tb/tb_sdram_init_seq.sv
module tb_sdram_init_seq;

    localparam int AW    = 12;
    localparam int MHZ   = 1;
    localparam int US    = 37;
    localparam int STAB  = MHZ * US;
    localparam int TRP   = 3;
    localparam int TMRD  = 2;
    localparam int TRC   = 5;
    localparam int NREF  = 3;
    localparam logic [AW-1:0] MODE = 12'h2A3;
    localparam int K_MRS = STAB + TRP;
    localparam int K_REF = K_MRS + TMRD;
    localparam int K_RDY = K_REF + NREF * TRC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dqm, init_ready;
    logic [AW-1:0] sd_addr;
    logic [1:0]    sd_ba;

    int checks = 0;
    int fails  = 0;
    int refs_seen;

    always #10 clk = ~clk;

    sdram_init_seq #(
        .ADDR_W(AW), .CLK_MHZ(MHZ), .STAB_US(US), .T_RP(TRP), .T_MRD(TMRD),
        .T_RC(TRC), .REF_COUNT(NREF), .MODE_WORD(MODE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
        .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm), .init_ready(init_ready)
    );

    function automatic logic [3:0] exp_cmd(int k);
        if (k == STAB)  return 4'b0010;
        if (k == K_MRS) return 4'b0000;
        for (int i = 0; i < NREF; i++) if (k == K_REF + i * TRC) return 4'b0001;
        return 4'b0111;
    endfunction

    function automatic logic exp_ready(int k);
        return k >= K_RDY;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_reset();
        logic [3:0] c;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        chk(c == 4'b0111 && sd_cke && sd_dqm && !init_ready, "R1", "reset outputs",
            {c, sd_cke, sd_dqm, init_ready}, {4'b0111, 3'b110});
    endtask

    task automatic check_cycle(int k, bit after_abort);
        logic [3:0] c, e;
        string tag;
        c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
        e = exp_cmd(k);
        tag = (e == 4'b0010) ? "R2" : (e == 4'b0000) ? "R3" : (e == 4'b0001) ? "R4" : "R5";
        if (after_abort && k == STAB) tag = "R9";
        chk(c == e, tag, $sformatf("command at cycle %0d", k), c, e);
        if (c == 4'b0001) refs_seen++;
        chk(sd_cke == 1'b1, "R8", "cke", sd_cke, 1);
        chk(init_ready == exp_ready(k), "R6", $sformatf("ready at cycle %0d", k),
            init_ready, exp_ready(k));
        chk(sd_dqm == !exp_ready(k), "R7", $sformatf("dqm at cycle %0d", k),
            sd_dqm, !exp_ready(k));
        if (e == 4'b0010) chk(sd_addr[10] == 1'b1, "R2", "A10 on precharge", sd_addr, 32'h400);
        if (e == 4'b0000) chk(sd_addr == MODE && sd_ba == 2'b00, "R3", "mode word",
                              {sd_ba, sd_addr}, MODE);
    endtask

    task automatic run(int ncyc, bit after_abort);
        @(negedge clk);
        rst_n = 1'b1;
        refs_seen = 0;
        #1 check_cycle(0, after_abort);
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            check_cycle(k, after_abort);
        end
    endtask

    task automatic do_reset(int ncyc);
        @(negedge clk);
        rst_n = 1'b0;
        #1 check_reset();
        repeat (ncyc) @(negedge clk);
        check_reset();
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks + 1);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4711);
        #1 check_reset();
        repeat (3) @(negedge clk);
        check_reset();

        run(K_RDY + 10, 1'b0);
        chk(refs_seen == NREF, "R4", "refresh count", refs_seen, NREF);

        do_reset(2);
        run(STAB, 1'b0);
        do_reset(1);
        run(K_RDY + 2, 1'b1);
        chk(refs_seen == NREF, "R4", "refresh count after restart", refs_seen, NREF);

        for (int t = 0; t < 14; t++) begin
            do_reset($urandom_range(1, 3));
            run($urandom_range(0, K_RDY + 8), 1'b1);
        end

        do_reset(2);
        run(K_RDY + 4, 1'b1);
        chk(refs_seen == NREF, "R4", "refresh count final", refs_seen, NREF);
        do_reset(1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule